// File: doc/BRIEF.md
# Debug bus access engine

This block gives an external debugger a path into system memory through three registers: an address register, a control/status register and a data register. The debugger loads the address, then writes the control word with its start bit set. The engine requests the system bus, waits for a grant and moves one byte, halfword or word. For block transfers it advances the address by the access size after every good transfer and counts down the remaining transfers.

Reads begin at once. Each later read in a block is started when the debugger reads the data register. Writes wait for the debugger to load the data register, and each such load sends one bus write. A data-valid flag paces this exchange with the debugger. An error flag reports an illegal size or a faulted bus transfer.

The state machine has four states. IDLE accepts register writes. ARB holds the bus request until grant. XFER holds the request until an acknowledge or an error response. HOLD waits for the debugger's next data-register access. The transitions are:
- launch: IDLE to ARB for a read, IDLE to HOLD for a write.
- grant: ARB to XFER.
- step: XFER to HOLD, taken when transfers remain.
- finish: XFER to IDLE, taken on the last transfer.
- fault: XFER to IDLE on an error response.
- resume: HOLD to ARB on a data-register read (read direction) or a data-register write (write direction).

Top module: `dbg_access_engine`

## Requirements
- R1: Reset clears the address, data and control/status registers, including the start, data-valid and error bits, and holds `bus_req` low.
- R2: The control word (`reg_sel`=1) has these fields: start at bit 31, map select at bits 30:28, priority at bits 27:26, direction at bit 25 (1 = write, 0 = read), size at bits 24:22, count at bits 21:6, data-valid at bit 1 and error at bit 0. Writing it with start clear stores the fields and launches nothing.
- R3: Size 0 means 8-bit, 1 means 16-bit and 2 means 32-bit. A start with any other size sets error, clears data-valid and starts no bus cycle.
- R4: On a read transfer, the acknowledged data is placed zero-extended in the data register and data-valid is set. A byte read takes the lane chosen by address bits 1:0. A halfword read takes the lane chosen by address bit 1.
- R5: A count of 0 or 1 performs exactly one transfer. The address does not change, and the count reads back as 0 afterwards.
- R6: In a block transfer (count > 1), each acknowledged transfer adds 1, 2 or 4 to the address and subtracts 1 from the count.
- R7: In a block read, a data-register read (`reg_sel`=2 with `reg_rd`) while the engine waits clears data-valid and starts the next bus read. After the last read, start clears and data-valid stays set.
- R8: A write launch waits for a data-register write, then issues one bus write. Byte data goes out replicated on all four lanes with a single byte enable, set by address bits 1:0. Halfword data goes out on both halves with enables 0011 or 1100, set by address bit 1. A word uses enables 1111. A single write sets data-valid when it completes.
- R9: A block write ends with both start and data-valid clear.
- R10: An error response sets error, clears data-valid and start, and leaves the address and count as they were.
- R11: While the request is asserted, `bus_map`, `bus_pri` and `bus_we` carry the launched map, priority and direction.
- R12: While start is set, writes to the address and control registers are ignored.
- R13: `bus_req` rises when a transfer is due. It stays high, with a stable address, until an acknowledge or an error response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 2 | Register select: 0 address, 1 control/status, 2 data |
| reg_wr | input | 1 | One-cycle register write strobe |
| reg_rd | input | 1 | One-cycle register read strobe (side effect on data only) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents |
| bus_req | output | 1 | Bus request, held for the whole transfer |
| bus_gnt | input | 1 | One-cycle grant |
| bus_addr | output | ADDR_W | Transfer address |
| bus_we | output | 1 | 1 for a write transfer |
| bus_be | output | 4 | Byte-lane enables |
| bus_wdata | output | 32 | Write data, lane-replicated |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Transfer completed without fault |
| bus_err | input | 1 | Transfer completed with fault |
| bus_map | output | 3 | Map select of the current access |
| bus_pri | output | 2 | Priority of the current access |

## Verification
The properties assume the following about the bus side:
- An acknowledge or an error comes only after a grant, in the transfer phase, and never both in one cycle.
- Grant and responses come only while the request is high.

The properties also assume that the debugger pulses `reg_wr` and `reg_rd` for one cycle each and never both together. The bench's bus responder obeys these rules by construction: it grants a raised request after a programmable delay, answers exactly once per grant, and drops all responses when the request falls. Its debugger tasks drive only single-strobe pulses away from the clock edge.

// File: rtl/dbgacc_pkg.sv
package dbgacc_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ARB,
        S_XFER,
        S_HOLD
    } acc_state_e;

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_CTRL = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;

    localparam logic [2:0] SZ_BYTE = 3'd0;
    localparam logic [2:0] SZ_HALF = 3'd1;
    localparam logic [2:0] SZ_WORD = 3'd2;

    localparam int CW_START   = 31;
    localparam int CW_MAP_LSB = 28;
    localparam int CW_PRI_LSB = 26;
    localparam int CW_RW      = 25;
    localparam int CW_SZ_LSB  = 22;
    localparam int CW_CNT_LSB = 6;
    localparam int CW_DV      = 1;
    localparam int CW_ERR     = 0;

    function automatic logic size_legal(input logic [2:0] sz);
        return sz <= SZ_WORD;
    endfunction

    function automatic logic [2:0] size_bytes(input logic [2:0] sz);
        logic [2:0] n;
        unique case (sz)
            SZ_BYTE: n = 3'd1;
            SZ_HALF: n = 3'd2;
            default: n = 3'd4;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/dbgacc_lanes.sv
module dbgacc_lanes
    import dbgacc_pkg::*;
(
    input  logic [2:0]  sz,
    input  logic [1:0]  lo,
    input  logic [31:0] src,
    input  logic [31:0] rd_bus,
    output logic [3:0]  be,
    output logic [31:0] wr_bus,
    output logic [31:0] rd_ext
);

    localparam int LANES = 4;

    logic [7:0] byte_sel;
    logic [15:0] half_sel;

    // one byte lane picked by the low address bits
    always_comb begin
        byte_sel = rd_bus[7:0];
        for (int i = 0; i < LANES; i++) begin
            if (lo == 2'(i)) byte_sel = rd_bus[8*i +: 8];
        end
        half_sel = lo[1] ? rd_bus[31:16] : rd_bus[15:0];
    end

    always_comb begin
        unique case (sz)
            SZ_BYTE: begin
                be     = 4'b0001 << lo;
                wr_bus = {LANES{src[7:0]}};
                rd_ext = {24'b0, byte_sel};
            end
            SZ_HALF: begin
                be     = lo[1] ? 4'b1100 : 4'b0011;
                wr_bus = {2{src[15:0]}};
                rd_ext = {16'b0, half_sel};
            end
            default: begin
                be     = 4'b1111;
                wr_bus = src;
                rd_ext = rd_bus;
            end
        endcase
    end

endmodule

// File: rtl/dbgacc_fsm.sv
module dbgacc_fsm
    import dbgacc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       launch,
    input  logic       launch_rw,
    input  logic       rw_q,
    input  logic       data_rd,
    input  logic       data_wr,
    input  logic       bus_gnt,
    input  logic       bus_ack,
    input  logic       bus_err,
    input  logic       last,
    output acc_state_e st,
    output logic       bus_req,
    output logic       done_ok,
    output logic       done_fault
);

    acc_state_e st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_d;
    end

    always_comb begin
        st_d = st;
        unique case (st)
            S_IDLE: if (launch) st_d = launch_rw ? S_HOLD : S_ARB;
            S_ARB:  if (bus_gnt) st_d = S_XFER;
            S_XFER: begin
                if (bus_err)      st_d = S_IDLE;
                else if (bus_ack) st_d = last ? S_IDLE : S_HOLD;
            end
            S_HOLD: begin
                if (rw_q ? data_wr : data_rd) st_d = S_ARB;
            end
            default: st_d = S_IDLE;
        endcase
    end

    always_comb begin
        bus_req    = (st == S_ARB) || (st == S_XFER);
        done_ok    = (st == S_XFER) && bus_ack && !bus_err;
        done_fault = (st == S_XFER) && bus_err;
    end

endmodule

// File: rtl/dbg_access_engine.sv
module dbg_access_engine
    import dbgacc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_we,
    output logic [3:0]        bus_be,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_ack,
    input  logic              bus_err,
    output logic [2:0]        bus_map,
    output logic [1:0]        bus_pri
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [ADDR_W-1:0] addr_q;
    logic [31:0]       data_q;
    logic [2:0]        map_q;
    logic [1:0]        pri_q;
    logic              rw_q;
    logic [2:0]        sz_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              blk_q;
    logic              start_q;
    logic              dv_q;
    logic              err_q;

    acc_state_e st;
    logic       done_ok, done_fault;

    // decoded debugger requests
    logic             idle, wr_addr, wr_ctrl, wr_data, rd_data;
    logic             go_start, go_legal, launch, last;
    logic [CNT_W-1:0] wr_cnt;
    logic [2:0]       wr_sz;
    logic [31:0]      lane_rd;
    logic [31:0]      ctrl_word;
    logic             unused_low_bits;

    assign idle     = (st == S_IDLE);
    assign wr_addr  = reg_wr && (reg_sel == SEL_ADDR);
    assign wr_ctrl  = reg_wr && (reg_sel == SEL_CTRL);
    assign wr_data  = reg_wr && (reg_sel == SEL_DATA);
    assign rd_data  = reg_rd && (reg_sel == SEL_DATA);
    assign wr_cnt   = reg_wdata[CW_CNT_LSB +: CNT_W];
    assign wr_sz    = reg_wdata[CW_SZ_LSB +: 3];
    assign go_start = idle && wr_ctrl && reg_wdata[CW_START];
    assign go_legal = size_legal(wr_sz);
    assign launch   = go_start && go_legal;
    assign last     = (cnt_q == CNT_ONE);
    assign unused_low_bits = ^reg_wdata[CW_CNT_LSB-1:0];

    dbgacc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .launch_rw  (reg_wdata[CW_RW]),
        .rw_q       (rw_q),
        .data_rd    (rd_data),
        .data_wr    (wr_data),
        .bus_gnt    (bus_gnt),
        .bus_ack    (bus_ack),
        .bus_err    (bus_err),
        .last       (last),
        .st         (st),
        .bus_req    (bus_req),
        .done_ok    (done_ok),
        .done_fault (done_fault)
    );

    dbgacc_lanes u_lanes (
        .sz     (sz_q),
        .lo     (addr_q[1:0]),
        .src    (data_q),
        .rd_bus (bus_rdata),
        .be     (bus_be),
        .wr_bus (bus_wdata),
        .rd_ext (lane_rd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            data_q  <= '0;
            map_q   <= '0;
            pri_q   <= '0;
            rw_q    <= 1'b0;
            sz_q    <= '0;
            cnt_q   <= '0;
            blk_q   <= 1'b0;
            start_q <= 1'b0;
            dv_q    <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (idle) begin
                if (wr_addr) addr_q <= reg_wdata[ADDR_W-1:0];
                if (wr_data) data_q <= reg_wdata;
                if (wr_ctrl) begin
                    map_q <= reg_wdata[CW_MAP_LSB +: 3];
                    pri_q <= reg_wdata[CW_PRI_LSB +: 2];
                    rw_q  <= reg_wdata[CW_RW];
                    sz_q  <= wr_sz;
                    cnt_q <= wr_cnt;
                end
                if (go_start) begin
                    dv_q <= 1'b0;
                    if (go_legal) begin
                        start_q <= 1'b1;
                        err_q   <= 1'b0;
                        blk_q   <= (wr_cnt > CNT_ONE);
                        if (wr_cnt == '0) cnt_q <= CNT_ONE;
                    end else begin
                        err_q <= 1'b1;
                    end
                end
            end
            if (st == S_HOLD) begin
                if (rw_q && wr_data) begin
                    data_q <= reg_wdata;
                    dv_q   <= 1'b0;
                end
                if (!rw_q && rd_data) dv_q <= 1'b0;
            end
            if (done_fault) begin
                err_q   <= 1'b1;
                dv_q    <= 1'b0;
                start_q <= 1'b0;
            end
            if (done_ok) begin
                if (!rw_q) data_q <= lane_rd;
                if (blk_q) addr_q <= addr_q + ADDR_W'(size_bytes(sz_q));
                cnt_q <= cnt_q - CNT_ONE;
                if (last) begin
                    start_q <= 1'b0;
                    dv_q    <= !(blk_q && rw_q);
                end else begin
                    dv_q <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        ctrl_word = '0;
        ctrl_word[CW_START]               = start_q;
        ctrl_word[CW_MAP_LSB +: 3]        = map_q;
        ctrl_word[CW_PRI_LSB +: 2]        = pri_q;
        ctrl_word[CW_RW]                  = rw_q;
        ctrl_word[CW_SZ_LSB +: 3]         = sz_q;
        ctrl_word[CW_CNT_LSB +: CNT_W]    = cnt_q;
        ctrl_word[CW_DV]                  = dv_q;
        ctrl_word[CW_ERR]                 = err_q;
    end

    always_comb begin
        unique case (reg_sel)
            SEL_ADDR: reg_rdata = 32'(addr_q);
            SEL_CTRL: reg_rdata = ctrl_word;
            SEL_DATA: reg_rdata = data_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign bus_addr = addr_q;
    assign bus_we   = rw_q;
    assign bus_map  = map_q;
    assign bus_pri  = pri_q;

endmodule

// File: rtl/dbgacc_chk.sv
module dbgacc_chk
    import dbgacc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input acc_state_e        st,
    input logic              bus_req,
    input logic              bus_ack,
    input logic              bus_err,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [3:0]        bus_be,
    input logic [2:0]        sz_q,
    input logic              start_q,
    input logic              dv_q,
    input logic              err_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [ADDR_W-1:0] addr_q,
    input logic              reg_wr,
    input logic [1:0]        reg_sel,
    input logic [31:0]       reg_wdata
);

    a_r13_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack && !bus_err) |=> bus_req);

    a_r13_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack && !bus_err) |=> $stable(bus_addr));

    a_r3_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && reg_wr && reg_sel == SEL_CTRL && reg_wdata[CW_START]
         && reg_wdata[CW_SZ_LSB +: 3] > SZ_WORD) |=> (err_q && !bus_req && !dv_q));

    a_r10_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_XFER && bus_err) |=>
        (err_q && !dv_q && !start_q && $stable(addr_q) && $stable(cnt_q)));

    a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_XFER && bus_ack && !bus_err) |=> (cnt_q == $past(cnt_q) - 1'b1));

    a_r8_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> ($countones(bus_be) ==
                     ((sz_q == SZ_BYTE) ? 1 : (sz_q == SZ_HALF) ? 2 : 4)));

    a_r7_busy_flag: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> start_q);

endmodule

bind dbg_access_engine dbgacc_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .bus_req   (bus_req),
    .bus_ack   (bus_ack),
    .bus_err   (bus_err),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .sz_q      (sz_q),
    .start_q   (start_q),
    .dv_q      (dv_q),
    .err_q     (err_q),
    .cnt_q     (cnt_q),
    .addr_q    (addr_q),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata)
);

// File: tb/sim_dbg_access_engine.sv
module sim_dbg_access_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        bus_req;
    logic        bus_gnt = 1'b0;
    logic [31:0] bus_addr;
    logic        bus_we;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = 32'd0;
    logic        bus_ack = 1'b0;
    logic        bus_err = 1'b0;
    logic [2:0]  bus_map;
    logic [1:0]  bus_pri;

    always #2 clk = ~clk;

    dbg_access_engine u0 (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err),
        .bus_map(bus_map), .bus_pri(bus_pri)
    );

    // ---------------- bus responder ----------------
    logic [31:0] mem [16];
    int gnt_dly = 0;
    int ack_dly = 0;
    int err_at  = -1;
    int xfer_no = 0;
    int sph = 0;
    int scnt = 0;

    always @(negedge clk) begin
        bus_gnt = 1'b0;
        bus_ack = 1'b0;
        bus_err = 1'b0;
        if (!rst_n) begin
            for (int i = 0; i < 16; i++)
                mem[i] = {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)} + 32'h8080_8080;
            sph = 0; scnt = 0;
        end else if (!bus_req) begin
            sph = 0; scnt = 0;
        end else if (sph == 0) begin
            if (scnt >= gnt_dly) begin bus_gnt = 1'b1; sph = 1; scnt = 0; end
            else scnt++;
        end else if (sph == 1) begin
            if (scnt >= ack_dly) begin
                if (xfer_no == err_at) bus_err = 1'b1;
                else begin
                    bus_ack = 1'b1;
                    if (bus_we) begin
                        for (int b = 0; b < 4; b++)
                            if (bus_be[b]) mem[bus_addr[5:2]][8*b +: 8] = bus_wdata[8*b +: 8];
                    end else bus_rdata = mem[bus_addr[5:2]];
                end
                xfer_no++; sph = 2;
            end else scnt++;
        end
    end

    // ---------------- behavioural reference ----------------
    int          m_ph = 0;        // 0 idle, 1 asking, 2 moving, 3 waiting debugger
    logic [31:0] m_addr = 0, m_data = 0;
    logic [2:0]  m_map = 0, m_sz = 0;
    logic [1:0]  m_pri = 0;
    logic        m_rw = 0, m_blk = 0, m_start = 0, m_dv = 0, m_err = 0;
    logic [15:0] m_cnt = 0;

    function automatic int nbytes(input logic [2:0] s);
        return (s == 3'd0) ? 1 : (s == 3'd1) ? 2 : 4;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_addr = 0; m_data = 0; m_map = 0; m_pri = 0; m_rw = 0;
            m_sz = 0; m_cnt = 0; m_blk = 0; m_start = 0; m_dv = 0; m_err = 0;
        end else begin
            case (m_ph)
                0: if (reg_wr) begin
                    if (reg_sel == 2'd0) m_addr = reg_wdata;
                    else if (reg_sel == 2'd2) m_data = reg_wdata;
                    else if (reg_sel == 2'd1) begin
                        m_map = reg_wdata[30:28]; m_pri = reg_wdata[27:26];
                        m_rw = reg_wdata[25]; m_sz = reg_wdata[24:22]; m_cnt = reg_wdata[21:6];
                        if (reg_wdata[31]) begin
                            m_dv = 0;
                            if (m_sz > 3'd2) m_err = 1;
                            else begin
                                m_err = 0; m_start = 1; m_blk = (m_cnt > 1);
                                if (m_cnt == 0) m_cnt = 1;
                                m_ph = m_rw ? 3 : 1;
                            end
                        end
                    end
                end
                1: if (bus_gnt) m_ph = 2;
                2: if (bus_err) begin
                        m_err = 1; m_dv = 0; m_start = 0; m_ph = 0;
                    end else if (bus_ack) begin
                        automatic logic fin = (m_cnt == 1);
                        automatic int sh = (m_sz == 3'd1) ? 16 * m_addr[1] : 8 * m_addr[1:0];
                        if (!m_rw) m_data = (m_sz == 3'd2) ? bus_rdata
                                          : (bus_rdata >> sh) & ((m_sz == 3'd0) ? 32'hFF : 32'hFFFF);
                        if (m_blk) m_addr = m_addr + nbytes(m_sz);
                        m_cnt = m_cnt - 1;
                        if (fin) begin m_start = 0; m_ph = 0; m_dv = !(m_blk && m_rw); end
                        else begin m_dv = 1; m_ph = 3; end
                    end
                3: if (reg_sel == 2'd2 && !m_rw && reg_rd) begin m_dv = 0; m_ph = 1; end
                   else if (reg_sel == 2'd2 && m_rw && reg_wr) begin
                       m_data = reg_wdata; m_dv = 0; m_ph = 1;
                   end
                default: m_ph = 0;
            endcase
        end
    end

    // ---------------- per-clock bus comparison ----------------
    int clk_chk = 0;
    int clk_bad = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            automatic logic exp_req = (m_ph == 1) || (m_ph == 2);
            clk_chk++;
            if (bus_req !== exp_req) begin
                clk_bad++;
                $display("FAIL R13 bus_req actual=%b expected=%b", bus_req, exp_req);
            end
            if (exp_req) begin
                automatic logic [3:0] e_be = (m_sz == 3'd0) ? (4'b0001 << m_addr[1:0])
                                           : (m_sz == 3'd1) ? (m_addr[1] ? 4'b1100 : 4'b0011) : 4'hF;
                automatic logic [31:0] e_wd = (m_sz == 3'd0) ? {4{m_data[7:0]}}
                                            : (m_sz == 3'd1) ? {2{m_data[15:0]}} : m_data;
                clk_chk += 3;
                if (bus_addr !== m_addr) begin
                    clk_bad++; $display("FAIL R6 bus_addr actual=%h expected=%h", bus_addr, m_addr);
                end
                if ({bus_map, bus_pri, bus_we} !== {m_map, m_pri, m_rw}) begin
                    clk_bad++; $display("FAIL R11 map/pri/we actual=%h expected=%h",
                                        {bus_map, bus_pri, bus_we}, {m_map, m_pri, m_rw});
                end
                if (bus_be !== e_be || (m_rw && bus_wdata !== e_wd)) begin
                    clk_bad++; $display("FAIL R8 lanes actual=%h/%h expected=%h/%h",
                                        bus_be, bus_wdata, e_be, e_wd);
                end
            end
        end
    end

    // ---------------- directed sequence ----------------
    int n_chk = 0;
    int n_bad = 0;
    logic timed_out = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] cw(input logic st, input logic [2:0] mp, input logic [1:0] pr,
                                       input logic rw, input logic [2:0] sz, input logic [15:0] cnt);
        return {st, mp, pr, rw, sz, cnt, 6'd0};
    endfunction

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd_pulse(input logic [1:0] s);
        @(negedge clk); reg_sel = s; reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] s, input logic [31:0] exp, input string tag);
        @(negedge clk); reg_sel = s; #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic settle();
        @(negedge clk);
        while (m_ph == 1 || m_ph == 2) @(negedge clk);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                // R1 reset state
                peek(2'd0, 32'h0, "R1 addr after reset");
                peek(2'd1, 32'h0, "R1 ctrl after reset");
                peek(2'd2, 32'h0, "R1 data after reset");
                check("R1 bus_req after reset", {31'd0, bus_req}, 32'd0);

                // R2 field readback without start
                wr(2'd1, cw(0, 3'd5, 2'd2, 1, 3'd1, 16'd7));
                repeat (3) @(negedge clk);
                check("R2 no launch", {31'd0, bus_req}, 32'd0);
                peek(2'd1, cw(0, 3'd5, 2'd2, 1, 3'd1, 16'd7), "R2 ctrl readback");

                // R3 illegal size
                wr(2'd1, cw(1, 3'd0, 2'd0, 0, 3'd3, 16'd0));
                repeat (4) @(negedge clk);
                check("R3 no bus cycle", {31'd0, bus_req}, 32'd0);
                peek(2'd1, cw(0, 3'd0, 2'd0, 0, 3'd3, 16'd0) | 32'h1, "R3 error set");

                // R4/R5 single byte read, lane 3
                wr(2'd0, 32'h23);
                wr(2'd1, cw(1, 3'd0, 2'd0, 0, 3'd0, 16'd0));
                settle();
                peek(2'd2, 32'h0000_00A3, "R4 byte read zero-extended");
                peek(2'd1, 32'h2, "R5 single read status");
                peek(2'd0, 32'h23, "R5 address unchanged");

                // R4/R5 single halfword read, upper half, count 1
                wr(2'd0, 32'h12);
                wr(2'd1, cw(1, 3'd0, 2'd0, 0, 3'd1, 16'd1));
                settle();
                peek(2'd2, 32'h0000_9392, "R4 halfword read upper lane");
                peek(2'd0, 32'h12, "R5 address unchanged count1");

                // R6/R7/R11/R12/R13 block word read with delays
                gnt_dly = 3; ack_dly = 2;
                wr(2'd0, 32'h10);
                wr(2'd1, cw(1, 3'd3, 2'd1, 0, 3'd2, 16'd3));
                settle();
                peek(2'd2, 32'h9392_9190, "R7 block read word 0");
                peek(2'd1, cw(1, 3'd3, 2'd1, 0, 3'd2, 16'd2) | 32'h2, "R6 count after first");
                wr(2'd0, 32'h3C);
                peek(2'd0, 32'h14, "R12 address write ignored while busy");
                rd_pulse(2'd2);
                settle();
                peek(2'd2, 32'h9796_9594, "R7 block read word 1");
                rd_pulse(2'd2);
                settle();
                peek(2'd2, 32'h9B9A_9998, "R7 block read word 2");
                peek(2'd0, 32'h1C, "R6 final address");
                peek(2'd1, cw(0, 3'd3, 2'd1, 0, 3'd2, 16'd0) | 32'h2, "R7 done with data-valid");
                gnt_dly = 0; ack_dly = 0;

                // R8 single byte write
                wr(2'd0, 32'h05);
                wr(2'd1, cw(1, 3'd0, 2'd0, 1, 3'd0, 16'd0));
                repeat (3) @(negedge clk);
                check("R8 write waits for data", {31'd0, bus_req}, 32'd0);
                wr(2'd2, 32'h0000_00A5);
                settle();
                check("R8 byte lane written", mem[1], 32'h8786_A584);
                peek(2'd1, cw(0, 3'd0, 2'd0, 1, 3'd0, 16'd0) | 32'h2, "R8 single write data-valid");

                // R9 block halfword write
                wr(2'd0, 32'h20);
                wr(2'd1, cw(1, 3'd0, 2'd0, 1, 3'd1, 16'd2));
                settle();
                wr(2'd2, 32'h0000_1234);
                settle();
                wr(2'd2, 32'h0000_BEEF);
                settle();
                check("R9 block write memory", mem[8], 32'hBEEF_1234);
                peek(2'd0, 32'h24, "R6 block write address");
                peek(2'd1, cw(0, 3'd0, 2'd0, 1, 3'd1, 16'd0), "R9 block write end flags");

                // R10 error on second transfer of a block read
                err_at = xfer_no + 1;
                wr(2'd0, 32'h30);
                wr(2'd1, cw(1, 3'd0, 2'd0, 0, 3'd2, 16'd4));
                settle();
                rd_pulse(2'd2);
                settle();
                peek(2'd0, 32'h34, "R10 address kept");
                peek(2'd1, cw(0, 3'd0, 2'd0, 0, 3'd2, 16'd3) | 32'h1, "R10 fault flags and count");
                err_at = -1;

                // R3 a legal start clears a stale error
                wr(2'd0, 32'h08);
                wr(2'd1, cw(1, 3'd0, 2'd0, 0, 3'd2, 16'd0));
                settle();
                peek(2'd1, cw(0, 3'd0, 2'd0, 0, 3'd2, 16'd0) | 32'h2, "R3 error cleared by good start");
                peek(2'd2, 32'h8B8A_8988, "R4 word read");
            end
            begin
                repeat (100000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        if (timed_out) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
        end
        $display("%0d/%0d checks passed", (n_chk + clk_chk) - (n_bad + clk_bad), n_chk + clk_chk);
        $finish;
    end

endmodule